// File: doc/BRIEF.md
# Shared-RAM Mailbox Host Interface

This block is the host-facing port of an I/O coprocessor that trades messages with the host through a shared byte-wide RAM. The host never addresses the RAM directly. It loads a 16-bit pointer through two byte registers and then reads or writes a data register. An optional auto-increment mode moves the pointer on after each data access. A status/control register holds the coprocessor's run (reset release) bit, a host-to-coprocessor interrupt request, two interrupt flags raised toward the host, and a bypass mode that shows two raw hardware lines.

Inside the RAM the two mailbox regions share one layout. The send region has a maximum-channel byte at 0x200, one state byte per channel at 0x201 + n, and 32-byte message slots at 0x220 + 32·n. The receive region repeats this at 0x300, 0x301 and 0x320. Byte 0x31F is the coprocessor's alive byte and 0x21F is a patch-control byte. Each channel state byte steps through idle (0), posted (1), taken (2) and done (3). A small coprocessor-side port reads and writes the RAM. The block watches the send state bytes so that a host posting a message and the coprocessor finishing one each produce an event without polling.

Top module: `mbox_host_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer, the control bits, both flags and every RAM byte are 0, and the host read data is 0.
- R2: Host registers are decoded from offset bits [3:1] only, so bit 0 is ignored. Offset 0 is pointer high, 2 is pointer low, 4 is status/control and 8 is RAM data. Any other offset reads 0 and ignores writes. Host read data appears on the edge that samples the read and holds until the next read.
- R3: With status bit 1 (auto-increment) set, every host data read or write advances the 16-bit pointer by one, wrapping from 0xFFFF to 0. The RAM uses the pointer's low 10 bits.
- R4: Status bits 0 to 3 read back as written. Bit 2 drives cp_run, where 0 holds the coprocessor in reset, and bit 3 drives cp_irq.
- R5: Status bits 4 and 5 are flags set by cp_int_set[0] and cp_int_set[1]. A host write of 1 to a flag bit clears it, and a set in the same cycle wins over the clear. host_irq is the OR of the flags. While the stored run bit is 0, both flags are forced to 0 on each edge.
- R6: With status bit 0 (bypass) set, status bit 6 reads hw_int_in and bit 7 reads the inverse of dma_req_in. With bypass clear, both read 0.
- R7: A host data write of value 1 that lands on a send state byte (0x201 to 0x207) makes cp_post_evt high for exactly the next cycle, with cp_post_chan equal to the address minus 0x201. Other values and other addresses, including 0x200 and 0x208, make no event.
- R8: A coprocessor write of value 3 to a send state byte sets flag bit 4 on that edge, provided run is 1.
- R9: If the host and the coprocessor write the same RAM byte in one cycle, the coprocessor's value is stored, and the host write makes no post event. Writes to different bytes in one cycle both land.
- R10: cp_rdata returns the byte at cp_addr one cycle after cp_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_ofs | input | 4 | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, registered |
| host_irq | output | 1 | Interrupt to the host, OR of the two flags |
| cp_run | output | 1 | Coprocessor run bit (0 holds it in reset) |
| cp_irq | output | 1 | Interrupt request to the coprocessor |
| cp_addr | input | 10 | Coprocessor RAM address |
| cp_we | input | 1 | Coprocessor write enable |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data, one cycle latency |
| cp_int_set | input | 2 | Pulses that set flag bits 4 and 5 |
| cp_post_evt | output | 1 | One-cycle message-posted event |
| cp_post_chan | output | 3 | Channel of the posted message |
| hw_int_in | input | 1 | Raw hardware interrupt, visible in bypass mode |
| dma_req_in | input | 1 | DMA request line, visible inverted in bypass mode |

## Verification
Host read data, pointer steps, control bits and flag sets triggered by the coprocessor all take effect on the rising edge that samples the access. They can be seen in the same cycle. The post event follows one edge after the landing write and lasts a single cycle. A flag clear caused by the run bit takes effect one edge after the run register drops, which is two edges after the status write. cp_rdata follows cp_addr by one edge. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares every output against that model on the next falling edge, so each result is sampled in the cycle it is due. Directed checks with known answers cover the wrap, the odd-offset aliasing, the channel boundaries and the same-byte write conflict.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Host register select, taken from offset bits [3:1]
   localparam logic [2:0] REG_ADDR_HI = 3'd0;
   localparam logic [2:0] REG_ADDR_LO = 3'd1;
   localparam logic [2:0] REG_CTRL    = 3'd2;
   localparam logic [2:0] REG_DATA    = 3'd4;

   // Per-channel mailbox state codes
   typedef enum logic [7:0] {
      CH_IDLE   = 8'd0,
      CH_POSTED = 8'd1,
      CH_TAKEN  = 8'd2,
      CH_DONE   = 8'd3
   } ch_state_e;

   // Writable control bits, bit 0 first from the right
   typedef struct packed {
      logic irq;
      logic run;
      logic autoinc;
      logic bypass;
   } ctrl_t;

endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
   parameter int DEPTH          = 1024,
   parameter int AW             = 10,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] h_addr,
   input  logic          h_we,
   input  logic [7:0]    h_wdata,
   output logic [7:0]    h_rdata,
   output logic          h_landed,
   input  logic [AW-1:0] cp_addr,
   input  logic          cp_we,
   input  logic [7:0]    cp_wdata,
   output logic [7:0]    cp_rdata
);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("mbox_ram: DEPTH must equal 2**AW");
   end

   logic [7:0] mem [DEPTH];

   assign h_rdata  = mem[h_addr];
   // the coprocessor port owns a byte both ports hit in one cycle
   assign h_landed = h_we && !(cp_we && (cp_addr == h_addr));

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else begin
            if (h_landed) mem[h_addr]  <= h_wdata;
            if (cp_we)    mem[cp_addr] <= cp_wdata;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (h_landed) mem[h_addr]  <= h_wdata;
         if (cp_we)    mem[cp_addr] <= cp_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cp_rdata <= '0;
      else        cp_rdata <= mem[cp_addr];
   end

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
   import mbox_pkg::*;
#(
   parameter int PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_sel,
   input  logic             acc_wr,
   input  logic [2:0]       acc_reg,
   input  logic [7:0]       wdata,
   input  logic [7:0]       ram_rdata,
   input  logic             hw_int_in,
   input  logic             dma_req_in,
   input  logic [1:0]       flag_set,
   output logic [PTR_W-1:0] ptr,
   output ctrl_t            ctrl,
   output logic [1:0]       flags,
   output logic [7:0]       rdata
);

   if (PTR_W <= 8 || PTR_W > 16) begin : g_bad_ptr
      $error("mbox_regs: PTR_W must be in 9..16");
   end

   logic       wr_en;
   logic       rd_en;
   logic [1:0] clr;
   logic [7:0] status_view;

   assign wr_en = acc_sel && acc_wr;
   assign rd_en = acc_sel && !acc_wr;
   assign clr   = (wr_en && acc_reg == REG_CTRL) ? wdata[5:4] : 2'b00;

   assign status_view = {ctrl.bypass & ~dma_req_in, ctrl.bypass & hw_int_in,
                         flags, ctrl.irq, ctrl.run, ctrl.autoinc, ctrl.bypass};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         ctrl  <= '0;
         flags <= '0;
         rdata <= '0;
      end else begin
         if (wr_en) begin
            case (acc_reg)
               REG_ADDR_HI: ptr[PTR_W-1:8] <= wdata[PTR_W-9:0];
               REG_ADDR_LO: ptr[7:0]       <= wdata;
               REG_CTRL:    ctrl           <= ctrl_t'(wdata[3:0]);
               default: ;
            endcase
         end
         if (acc_sel && acc_reg == REG_DATA && ctrl.autoinc)
            ptr <= ptr + PTR_W'(1);

         if (!ctrl.run) flags <= '0;
         else           flags <= (flags & ~clr) | flag_set;

         if (rd_en) begin
            case (acc_reg)
               REG_ADDR_HI: rdata <= 8'(ptr >> 8);
               REG_ADDR_LO: rdata <= ptr[7:0];
               REG_CTRL:    rdata <= status_view;
               REG_DATA:    rdata <= ram_rdata;
               default:     rdata <= '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/mbox_evt.sv
module mbox_evt
   import mbox_pkg::*;
#(
   parameter int AW        = 10,
   parameter int CHANNELS  = 7,
   parameter int SEND_BASE = 512,
   parameter int CHW       = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           h_landed,
   input  logic [AW-1:0]  h_addr,
   input  logic [7:0]     h_wdata,
   input  logic           cp_we,
   input  logic [AW-1:0]  cp_addr,
   input  logic [7:0]     cp_wdata,
   output logic           post_evt,
   output logic [CHW-1:0] post_chan,
   output logic           done_hit
);

   if (SEND_BASE + CHANNELS >= (1 << AW)) begin : g_bad_base
      $error("mbox_evt: send state bytes fall outside the RAM");
   end

   function automatic logic is_state_byte(input logic [AW-1:0] a);
      return (int'(a) > SEND_BASE) && (int'(a) <= SEND_BASE + CHANNELS);
   endfunction

   logic post_now;

   assign post_now = h_landed && is_state_byte(h_addr) && (h_wdata == 8'(CH_POSTED));
   assign done_hit = cp_we && is_state_byte(cp_addr) && (cp_wdata == 8'(CH_DONE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         post_evt  <= 1'b0;
         post_chan <= '0;
      end else begin
         post_evt <= post_now;
         if (post_now) post_chan <= CHW'(h_addr - AW'(SEND_BASE + 1));
      end
   end

endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
   import mbox_pkg::*;
#(
   parameter int PTR_W     = 16,
   parameter int RAM_BYTES = 1024,
   parameter int CHANNELS  = 7,
   parameter int SEND_BASE = 512,
   parameter bit CLEAR_RAM = 1'b1,
   localparam int RAM_AW   = $clog2(RAM_BYTES),
   localparam int CHW      = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [3:0]        bus_ofs,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              host_irq,
   output logic              cp_run,
   output logic              cp_irq,
   input  logic [RAM_AW-1:0] cp_addr,
   input  logic              cp_we,
   input  logic [7:0]        cp_wdata,
   output logic [7:0]        cp_rdata,
   input  logic [1:0]        cp_int_set,
   output logic              cp_post_evt,
   output logic [CHW-1:0]    cp_post_chan,
   input  logic              hw_int_in,
   input  logic              dma_req_in
);

   if (RAM_AW > PTR_W) begin : g_bad_ram
      $error("mbox_host_port: RAM larger than the pointer reach");
   end
   if (CHANNELS < 1 || CHANNELS > 31) begin : g_bad_chan
      $error("mbox_host_port: CHANNELS must be in 1..31");
   end

   logic [2:0]        acc_reg;
   logic              unused_ofs_bit;
   logic [PTR_W-1:0]  ptr_q;
   ctrl_t             ctrl_q;
   logic [1:0]        flags_q;
   logic [RAM_AW-1:0] h_addr;
   logic              h_we;
   logic              h_landed;
   logic [7:0]        h_rdata;
   logic              done_hit;

   assign acc_reg        = bus_ofs[3:1];
   assign unused_ofs_bit = bus_ofs[0];
   assign h_addr         = ptr_q[RAM_AW-1:0];
   assign h_we           = bus_sel && bus_wr && (acc_reg == REG_DATA);

   mbox_regs #(.PTR_W(PTR_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_sel    (bus_sel),
      .acc_wr     (bus_wr),
      .acc_reg    (acc_reg),
      .wdata      (bus_wdata),
      .ram_rdata  (h_rdata),
      .hw_int_in  (hw_int_in),
      .dma_req_in (dma_req_in),
      .flag_set   (cp_int_set | {1'b0, done_hit}),
      .ptr        (ptr_q),
      .ctrl       (ctrl_q),
      .flags      (flags_q),
      .rdata      (bus_rdata)
   );

   mbox_ram #(.DEPTH(RAM_BYTES), .AW(RAM_AW), .CLEAR_ON_RESET(CLEAR_RAM)) ram_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .h_addr   (h_addr),
      .h_we     (h_we),
      .h_wdata  (bus_wdata),
      .h_rdata  (h_rdata),
      .h_landed (h_landed),
      .cp_addr  (cp_addr),
      .cp_we    (cp_we),
      .cp_wdata (cp_wdata),
      .cp_rdata (cp_rdata)
   );

   mbox_evt #(.AW(RAM_AW), .CHANNELS(CHANNELS), .SEND_BASE(SEND_BASE), .CHW(CHW)) evt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .h_landed  (h_landed),
      .h_addr    (h_addr),
      .h_wdata   (bus_wdata),
      .cp_we     (cp_we),
      .cp_addr   (cp_addr),
      .cp_wdata  (cp_wdata),
      .post_evt  (cp_post_evt),
      .post_chan (cp_post_chan),
      .done_hit  (done_hit)
   );

   assign host_irq = |flags_q;
   assign cp_run   = ctrl_q.run;
   assign cp_irq   = ctrl_q.irq;

endmodule

// File: rtl/mbox_host_port_chk.sv
module mbox_host_port_chk #(
   parameter int PTR_W    = 16,
   parameter int AW       = 10,
   parameter int CHW      = 3,
   parameter int CHANNELS = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [2:0]       bus_reg,
   input logic [7:0]       bus_wdata,
   input logic             cp_run,
   input logic             host_irq,
   input logic             cp_post_evt,
   input logic [CHW-1:0]   cp_post_chan,
   input logic             cp_we,
   input logic [AW-1:0]    cp_addr,
   input logic [AW-1:0]    h_addr,
   input logic [PTR_W-1:0] ptr,
   input logic             autoinc
);

   // R3
   autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_reg == 3'd4 && autoinc) |=> (ptr == $past(ptr) + PTR_W'(1)));

   // R4
   run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_reg == 3'd2) |=> (cp_run == $past(bus_wdata[2])));

   // R5
   flags_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cp_run |=> !host_irq);

   // R7
   post_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_post_evt |-> $past(bus_sel && bus_wr && bus_reg == 3'd4 && bus_wdata == 8'h01));

   // R7
   chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_post_evt |-> (int'(cp_post_chan) < CHANNELS));

   // R9
   cp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_post_evt |-> !$past(cp_we && cp_addr == h_addr));

endmodule

bind mbox_host_port mbox_host_port_chk #(
   .PTR_W(PTR_W), .AW(RAM_AW), .CHW(CHW), .CHANNELS(CHANNELS)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .bus_reg      (bus_ofs[3:1]),
   .bus_wdata    (bus_wdata),
   .cp_run       (cp_run),
   .host_irq     (host_irq),
   .cp_post_evt  (cp_post_evt),
   .cp_post_chan (cp_post_chan),
   .cp_we        (cp_we),
   .cp_addr      (cp_addr),
   .h_addr       (h_addr),
   .ptr          (ptr_q),
   .autoinc      (ctrl_q.autoinc)
);

// File: tb/mbox_host_port_tb_top.sv
`timescale 1ns/1ps
module mbox_host_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_ofs = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       host_irq, cp_run, cp_irq;
   logic [9:0] cp_addr = '0;
   logic       cp_we = 1'b0;
   logic [7:0] cp_wdata = '0;
   logic [7:0] cp_rdata;
   logic [1:0] cp_int_set = '0;
   logic       cp_post_evt;
   logic [2:0] cp_post_chan;
   logic       hw_int_in = 1'b0, dma_req_in = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mbox_host_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .host_irq(host_irq), .cp_run(cp_run), .cp_irq(cp_irq),
      .cp_addr(cp_addr), .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
      .cp_int_set(cp_int_set), .cp_post_evt(cp_post_evt), .cp_post_chan(cp_post_chan),
      .hw_int_in(hw_int_in), .dma_req_in(dma_req_in)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0]  m_ram [1024];
   logic [15:0] m_ptr;
   logic        m_byp, m_ai, m_run, m_irq, m_f4, m_f5, m_evt;
   logic [2:0]  m_chan;
   logic [7:0]  m_rd, m_cprd;

   always @(posedge clk) begin : model
      logic [2:0] r;
      logic [9:0] ha;
      logic [1:0] clr, setv;
      logic [7:0] stv;
      bit         evt;
      if (!rst_n) begin
         foreach (m_ram[i]) m_ram[i] = 8'h00;
         m_ptr = 0; m_byp = 0; m_ai = 0; m_run = 0; m_irq = 0;
         m_f4 = 0; m_f5 = 0; m_evt = 0; m_chan = 0; m_rd = 0; m_cprd = 0;
      end else begin
         r    = bus_ofs[3:1];
         ha   = m_ptr[9:0];
         stv  = {m_byp & ~dma_req_in, m_byp & hw_int_in, m_f5, m_f4, m_irq, m_run, m_ai, m_byp};
         m_cprd = m_ram[cp_addr];
         if (bus_sel && !bus_wr) begin
            case (r)
               3'd0: m_rd = m_ptr[15:8];
               3'd1: m_rd = m_ptr[7:0];
               3'd2: m_rd = stv;
               3'd4: m_rd = m_ram[ha];
               default: m_rd = 8'h00;
            endcase
         end
         evt = 0; clr = 2'b00; setv = cp_int_set;
         if (bus_sel && bus_wr) begin
            case (r)
               3'd0: m_ptr[15:8] = bus_wdata;
               3'd1: m_ptr[7:0]  = bus_wdata;
               3'd2: clr = bus_wdata[5:4];
               3'd4: if (!(cp_we && cp_addr == ha)) begin
                  m_ram[ha] = bus_wdata;
                  if (ha >= 10'h201 && ha <= 10'h207 && bus_wdata == 8'h01) begin
                     evt = 1; m_chan = 3'(ha - 10'h201);
                  end
               end
               default: ;
            endcase
         end
         if (cp_we) begin
            m_ram[cp_addr] = cp_wdata;
            if (cp_addr >= 10'h201 && cp_addr <= 10'h207 && cp_wdata == 8'h03) setv[0] = 1'b1;
         end
         if (!m_run) {m_f5, m_f4} = 2'b00;
         else        {m_f5, m_f4} = ({m_f5, m_f4} & ~clr) | setv;
         if (bus_sel && bus_wr && r == 3'd2) {m_irq, m_run, m_ai, m_byp} = bus_wdata[3:0];
         if (bus_sel && r == 3'd4 && m_ai) m_ptr = m_ptr + 16'd1;
         m_evt = evt;
      end
   end

   // every-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 bus_rdata", bus_rdata, m_rd);
         chk("R10 cp_rdata", cp_rdata, m_cprd);
         chk("R5 host_irq", {7'd0, host_irq}, {7'd0, m_f4 | m_f5});
         chk("R4 cp_run", {7'd0, cp_run}, {7'd0, m_run});
         chk("R4 cp_irq", {7'd0, cp_irq}, {7'd0, m_irq});
         chk("R7 cp_post_evt", {7'd0, cp_post_evt}, {7'd0, m_evt});
         if (m_evt) chk("R7 cp_post_chan", {5'd0, cp_post_chan}, {5'd0, m_chan});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic hwr(input logic [3:0] o, input logic [7:0] d);
      bus_sel = 1; bus_wr = 1; bus_ofs = o; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic hrd(input logic [3:0] o, output logic [7:0] d);
      bus_sel = 1; bus_wr = 0; bus_ofs = o;
      @(negedge clk);
      bus_sel = 0;
      d = bus_rdata;
   endtask

   task automatic cwr(input logic [9:0] a, input logic [7:0] d);
      cp_we = 1; cp_addr = a; cp_wdata = d;
      @(negedge clk);
      cp_we = 0;
   endtask

   task automatic crd(input logic [9:0] a, output logic [7:0] d);
      cp_addr = a;
      @(negedge clk);
      d = cp_rdata;
   endtask

   task automatic setptr(input logic [15:0] p);
      hwr(4'd0, p[15:8]);
      hwr(4'd2, p[7:0]);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin : stim
      logic [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hrd(4'd4, v); chk("R1 status after reset", v, 8'h00);
      hrd(4'd8, v); chk("R1 ram byte 0 after reset", v, 8'h00);
      crd(10'h3FF, v); chk("R1 ram top byte after reset", v, 8'h00);

      // R2 decode and odd-offset aliasing
      hwr(4'd0, 8'h02);
      hwr(4'd3, 8'h20);
      hrd(4'd1, v); chk("R2 addr high via offset 1", v, 8'h02);
      hrd(4'd2, v); chk("R2 addr low", v, 8'h20);
      hrd(4'd6, v); chk("R2 unused offset reads 0", v, 8'h00);

      // R4 control bits
      hwr(4'd4, 8'h06);
      chk("R4 run bit drives cp_run", {7'd0, cp_run}, 8'h01);
      hrd(4'd5, v); chk("R4 status readback", v, 8'h06);

      // R3 auto-increment
      hwr(4'd8, 8'hA5);
      hwr(4'd8, 8'h5A);
      hrd(4'd2, v); chk("R3 pointer after two writes", v, 8'h22);
      hwr(4'd2, 8'h20);
      hrd(4'd8, v); chk("R3 first read", v, 8'hA5);
      hrd(4'd8, v); chk("R3 second read", v, 8'h5A);
      hrd(4'd2, v); chk("R3 pointer after two reads", v, 8'h22);
      setptr(16'hFFFF);
      hwr(4'd8, 8'h77);
      hrd(4'd0, v); chk("R3 wrap high", v, 8'h00);
      hrd(4'd2, v); chk("R3 wrap low", v, 8'h00);

      // R10 coprocessor read
      crd(10'h3FF, v); chk("R10 cp read of 0x3FF", v, 8'h77);

      // R7 post event
      setptr(16'h0203);
      hwr(4'd8, 8'h01);
      chk("R7 event pulses", {7'd0, cp_post_evt}, 8'h01);
      chk("R7 channel 2", {5'd0, cp_post_chan}, 8'h02);
      @(negedge clk);
      chk("R7 event is one cycle", {7'd0, cp_post_evt}, 8'h00);
      hwr(4'd8, 8'h02);
      chk("R7 no event for state 2", {7'd0, cp_post_evt}, 8'h00);

      // R8 done from coprocessor
      cwr(10'h203, 8'h03);
      chk("R8 host_irq on done", {7'd0, host_irq}, 8'h01);
      hrd(4'd4, v); chk("R8 flag bit 4", v, 8'h16);

      // R5 flags
      hwr(4'd4, 8'h16);
      chk("R5 write-one clears", {7'd0, host_irq}, 8'h00);
      cp_int_set = 2'b10; @(negedge clk); cp_int_set = 2'b00;
      hrd(4'd4, v); chk("R5 flag bit 5 set", v, 8'h26);
      cp_int_set = 2'b10; hwr(4'd4, 8'h26); cp_int_set = 2'b00;
      chk("R5 set wins over clear", {7'd0, host_irq}, 8'h01);
      hwr(4'd4, 8'h00);
      chk("R4 run low", {7'd0, cp_run}, 8'h00);
      @(negedge clk);
      chk("R5 flags cleared by run low", {7'd0, host_irq}, 8'h00);
      cp_int_set = 2'b01; @(negedge clk); cp_int_set = 2'b00;
      chk("R5 set ignored while run low", {7'd0, host_irq}, 8'h00);

      // R6 bypass
      hw_int_in = 1; dma_req_in = 0;
      hwr(4'd4, 8'h05);
      hrd(4'd4, v); chk("R6 bypass lines shown", v, 8'hC5);
      hw_int_in = 0; dma_req_in = 1;
      hrd(4'd4, v); chk("R6 bypass lines idle", v, 8'h05);
      hw_int_in = 1; dma_req_in = 0;
      hwr(4'd4, 8'h04);
      hrd(4'd4, v); chk("R6 lines hidden without bypass", v, 8'h04);

      // R9 write conflict
      setptr(16'h0205);
      cp_we = 1; cp_addr = 10'h205; cp_wdata = 8'h02;
      hwr(4'd8, 8'h01);
      cp_we = 0;
      chk("R9 no event when host write lost", {7'd0, cp_post_evt}, 8'h00);
      crd(10'h205, v); chk("R9 coprocessor value kept", v, 8'h02);
      hwr(4'd2, 8'h06);
      cp_we = 1; cp_addr = 10'h100; cp_wdata = 8'h33;
      hwr(4'd8, 8'h01);
      cp_we = 0;
      chk("R9 event when bytes differ", {7'd0, cp_post_evt}, 8'h01);
      chk("R9 channel 5", {5'd0, cp_post_chan}, 8'h05);
      crd(10'h100, v); chk("R9 coprocessor byte landed", v, 8'h33);
      hrd(4'd8, v); chk("R9 host byte landed", v, 8'h01);

      // R7 channel boundaries
      hwr(4'd2, 8'h07); hwr(4'd8, 8'h01);
      chk("R7 last channel", {5'd0, cp_post_chan}, 8'h06);
      hwr(4'd2, 8'h08); hwr(4'd8, 8'h01);
      chk("R7 past last channel", {7'd0, cp_post_evt}, 8'h00);
      hwr(4'd2, 8'h00); hwr(4'd8, 8'h01);
      chk("R7 max-channel byte", {7'd0, cp_post_evt}, 8'h00);

      // R4 irq bit, R2 ignored write
      hwr(4'd4, 8'h0C);
      chk("R4 cp_irq set", {7'd0, cp_irq}, 8'h01);
      hwr(4'd6, 8'hFF);
      hrd(4'd4, v); chk("R2 write to unused offset ignored", v, 8'h0C);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule